// File: doc/BRIEF.md
# Control-Selected Eight-Bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for two 8-bit operands. It holds four function units side by side. The first is a logic unit that gives OR or its inverse. The second is a logic unit that gives AND or its inverse. The third is an adder/subtractor. The fourth is an 8x8 multiplier. A 2-bit unit select picks which unit reaches the 16-bit result bus, and the two logic units and the arithmetic unit each take their own mode bit.

The arithmetic unit is a ripple chain of identical 1-bit cells. Each cell is a full adder when its mode input is low and a full subtractor when it is high. The multiplier reuses the same cell, with the mode tied low, as the full adder in each row of its shift-and-add array. The four unit outputs, each with its flag, pass through a 4:1 selector. That selector is a two-level tree of three 2:1 selector cells.

Top module: `alu8_core`

## Requirements
- R1: With unit_sel = 2'b00 and lor_mode = 0, res[7:0] is the bitwise NOR of op_a and op_b.
- R2: With unit_sel = 2'b00 and lor_mode = 1, res[7:0] is the bitwise OR of op_a and op_b.
- R3: With unit_sel = 2'b01 and land_mode = 0, res[7:0] is the bitwise NAND of op_a and op_b.
- R4: With unit_sel = 2'b01 and land_mode = 1, res[7:0] is the bitwise AND of op_a and op_b.
- R5: With unit_sel = 2'b10 and arith_sub = 0, res[7:0] is (op_a + op_b) mod 256 and cb_flag is the carry out of bit 7.
- R6: With unit_sel = 2'b10 and arith_sub = 1, res[7:0] is (op_a - op_b) mod 256 and cb_flag is the borrow out of bit 7, which is 1 exactly when op_a < op_b as unsigned numbers.
- R7: With unit_sel = 2'b11, res is the full 16-bit unsigned product op_a * op_b.
- R8: For unit_sel values 2'b00, 2'b01 and 2'b10, res[15:8] is zero.
- R9: cb_flag is 0 whenever unit_sel is not 2'b10.
- R10: The mode bits of the units that are not selected have no effect on res or cb_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand (minuend in subtract mode) |
| op_b | input | 8 | Second operand (subtrahend in subtract mode) |
| unit_sel | input | 2 | Unit select: 00 OR-type, 01 AND-type, 10 add/subtract, 11 multiply |
| lor_mode | input | 1 | OR-type unit mode: 0 inverted (NOR), 1 plain (OR) |
| land_mode | input | 1 | AND-type unit mode: 0 inverted (NAND), 1 plain (AND) |
| arith_sub | input | 1 | Arithmetic unit mode: 0 add, 1 subtract |
| res | output | 16 | Selected unit result, zero-extended for the 8-bit units |
| cb_flag | output | 1 | Carry (add) or borrow (subtract) from the arithmetic unit, else 0 |

## Verification
The carry/borrow flag and the result upper byte are the two things that can change together in one vector. A subtract or add that produces a carry or borrow sets the flag. A multiply of large operands fills the upper byte, and it must leave the flag clear. Back-to-back vectors move between these units while the operands stay the same: for example 0xFF with 0xFF in add mode and then in multiply mode, and 0x00 minus 0x80 and then the product of the same pair. Each vector is judged on all seventeen output bits together against an independent model. Any flag that lingers or any upper byte that leaks shows up as a mismatch in that cycle.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
   typedef enum logic [1:0] {
      USEL_ORX   = 2'b00,
      USEL_ANDX  = 2'b01,
      USEL_ARITH = 2'b10,
      USEL_MUL   = 2'b11
   } usel_e;

   localparam int unsigned DEF_W = 8;

   function automatic int unsigned sel_width(input int unsigned n_units);
      return (n_units <= 1) ? 1 : $clog2(n_units);
   endfunction
endpackage

// File: rtl/alu8_cell.sv
`timescale 1ns/1ps
// Unified 1-bit cell: full adder (mode=0) or full subtractor (mode=1).
module alu8_cell (
   input  logic a,
   input  logic b,
   input  logic ci,
   input  logic mode,
   output logic s,
   output logic co
);
   logic half;
   assign half = a ^ b;
   assign s    = half ^ ci;
   always_comb begin
      if (mode) co = (~a & b) | (ci & ~half);
      else      co = (a & b) | (ci & half);
   end
endmodule

// File: rtl/alu8_ripple.sv
`timescale 1ns/1ps
module alu8_ripple #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         sub,
   output logic [W-1:0] s,
   output logic         cb
);
   logic [W:0] chain;
   assign chain[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_bit
      alu8_cell u_cell (
         .a(x[i]), .b(y[i]), .ci(chain[i]), .mode(sub),
         .s(s[i]), .co(chain[i+1])
      );
   end
   assign cb = chain[W];

   always_comb begin
      if (!sub) begin
         assert_add_R5: assert ({cb, s} == ({1'b0, x} + {1'b0, y}))
            else $error("ripple add mismatch");
      end else begin
         assert_sub_R6: assert ((s == W'(x - y)) && (cb == (x < y)))
            else $error("ripple subtract mismatch");
      end
   end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
// Dual-function logic unit: ctrl=0 gives inverted gate, ctrl=1 plain gate.
module alu8_logic #(
   parameter int unsigned W      = 8,
   parameter bit          IS_AND = 1'b0
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         ctrl,
   output logic [W-1:0] z
);
   logic [W-1:0] core;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IS_AND) begin : g_and
         assign core[i] = x[i] & y[i];
      end else begin : g_or
         assign core[i] = x[i] | y[i];
      end
      assign z[i] = ctrl ? core[i] : ~core[i];
   end

   if (IS_AND) begin : g_chk_and
      always_comb begin
         if (ctrl) begin
            assert_and_R4: assert (((z & ~x) == '0) && ((z & ~y) == '0) && ((z | ~x | ~y) == '1))
               else $error("AND unit mismatch");
         end else begin
            assert_nand_R3: assert (((z | x) == '1) && ((z | y) == '1) && ((z & x & y) == '0))
               else $error("NAND unit mismatch");
         end
      end
   end else begin : g_chk_or
      always_comb begin
         if (ctrl) begin
            assert_or_R2: assert (((z & ~x & ~y) == '0) && ((z | ~x) == '1) && ((z | ~y) == '1))
               else $error("OR unit mismatch");
         end else begin
            assert_nor_R1: assert (((z & x) == '0) && ((z & y) == '0) && ((z | x | y) == '1))
               else $error("NOR unit mismatch");
         end
      end
   end
endmodule

// File: rtl/alu8_mult.sv
`timescale 1ns/1ps
// Shift-and-add array multiplier; each row is a ripple of add-mode cells.
module alu8_mult #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-1:0] p
);
   logic [W-1:0] pp   [W];
   logic [W-1:0] rsum [W];
   logic [W-1:0] rcar;

   for (genvar i = 0; i < W; i++) begin : g_pp
      assign pp[i] = x & {W{y[i]}};
   end

   assign rsum[0] = pp[0];
   assign rcar[0] = 1'b0;

   for (genvar i = 1; i < W; i++) begin : g_row
      logic [W-1:0] shifted;
      assign shifted = {rcar[i-1], rsum[i-1][W-1:1]};
      alu8_ripple #(.W(W)) u_row (
         .x(shifted), .y(pp[i]), .sub(1'b0),
         .s(rsum[i]), .cb(rcar[i])
      );
   end

   for (genvar i = 0; i < W; i++) begin : g_low
      assign p[i] = rsum[i][0];
   end
   assign p[2*W-1:W] = {rcar[W-1], rsum[W-1][W-1:1]};

   always_comb begin
      assert_prod_R7: assert (p == ((2*W)'(x) * (2*W)'(y)))
         else $error("multiplier mismatch");
   end
endmodule

// File: rtl/alu8_mux.sv
`timescale 1ns/1ps
module alu8_mux2 #(
   parameter int unsigned DW = 17
) (
   input  logic [DW-1:0] d0,
   input  logic [DW-1:0] d1,
   input  logic          s,
   output logic [DW-1:0] y
);
   assign y = s ? d1 : d0;
endmodule

// Two-level tree of three 2:1 cells.
module alu8_mux4 #(
   parameter int unsigned DW = 17
) (
   input  logic [DW-1:0] d0,
   input  logic [DW-1:0] d1,
   input  logic [DW-1:0] d2,
   input  logic [DW-1:0] d3,
   input  logic [1:0]    s,
   output logic [DW-1:0] y
);
   logic [DW-1:0] lo, hi;

   alu8_mux2 #(.DW(DW)) u_lo  (.d0(d0), .d1(d1), .s(s[0]), .y(lo));
   alu8_mux2 #(.DW(DW)) u_hi  (.d0(d2), .d1(d3), .s(s[0]), .y(hi));
   alu8_mux2 #(.DW(DW)) u_top (.d0(lo), .d1(hi), .s(s[1]), .y(y));

   always_comb begin
      case (s)
         2'b00:   assert_sel0_R10: assert (y == d0) else $error("mux leg 0");
         2'b01:   assert_sel1_R10: assert (y == d1) else $error("mux leg 1");
         2'b10:   assert_sel2_R10: assert (y == d2) else $error("mux leg 2");
         default: assert_sel3_R10: assert (y == d3) else $error("mux leg 3");
      endcase
   end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core #(
   parameter int unsigned W = alu8_pkg::DEF_W
) (
   input  logic [W-1:0]   op_a,
   input  logic [W-1:0]   op_b,
   input  logic [1:0]     unit_sel,
   input  logic           lor_mode,
   input  logic           land_mode,
   input  logic           arith_sub,
   output logic [2*W-1:0] res,
   output logic           cb_flag
);
   import alu8_pkg::*;

   localparam int unsigned RW = 2 * W;
   localparam int unsigned DW = RW + 1;
   localparam int unsigned SW = sel_width(4);

   if (W < 2) begin : g_bad_w
      $error("alu8_core: W must be at least 2");
   end
   if (SW != 2) begin : g_bad_sel
      $error("alu8_core: select width must be 2");
   end

   logic [W-1:0]  or_out, and_out, as_out;
   logic          as_cb;
   logic [RW-1:0] mul_out;
   logic [DW-1:0] leg [4];
   logic [DW-1:0] picked;

   alu8_logic #(.W(W), .IS_AND(1'b0)) u_orx (
      .x(op_a), .y(op_b), .ctrl(lor_mode), .z(or_out));
   alu8_logic #(.W(W), .IS_AND(1'b1)) u_andx (
      .x(op_a), .y(op_b), .ctrl(land_mode), .z(and_out));
   alu8_ripple #(.W(W)) u_arith (
      .x(op_a), .y(op_b), .sub(arith_sub), .s(as_out), .cb(as_cb));
   alu8_mult #(.W(W)) u_mul (
      .x(op_a), .y(op_b), .p(mul_out));

   assign leg[USEL_ORX]   = {1'b0,  {W{1'b0}}, or_out};
   assign leg[USEL_ANDX]  = {1'b0,  {W{1'b0}}, and_out};
   assign leg[USEL_ARITH] = {as_cb, {W{1'b0}}, as_out};
   assign leg[USEL_MUL]   = {1'b0,  mul_out};

   alu8_mux4 #(.DW(DW)) u_sel (
      .d0(leg[0]), .d1(leg[1]), .d2(leg[2]), .d3(leg[3]),
      .s(unit_sel), .y(picked));

   assign res     = picked[RW-1:0];
   assign cb_flag = picked[RW];

   always_comb begin
      if (unit_sel != USEL_ARITH) begin
         assert_flag_idle_R9: assert (cb_flag == 1'b0)
            else $error("flag set outside arithmetic unit");
      end
      if (unit_sel != USEL_MUL) begin
         assert_zero_ext_R8: assert (res[RW-1:W] == '0)
            else $error("upper byte not zero");
      end
   end
endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [7:0]  op_a = '0, op_b = '0;
   logic [1:0]  unit_sel = '0;
   logic        lor_mode = 1'b0, land_mode = 1'b0, arith_sub = 1'b0;
   logic [15:0] res;
   logic        cb_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [16:0] exp_q [$];
   string       tag_q [$];

   alu8_core dut (
      .op_a(op_a), .op_b(op_b), .unit_sel(unit_sel),
      .lor_mode(lor_mode), .land_mode(land_mode), .arith_sub(arith_sub),
      .res(res), .cb_flag(cb_flag));

   function automatic logic [16:0] model(input logic [7:0] x, y, input logic [1:0] s,
                                         input logic lm, am, sm);
      logic [8:0] sum9;
      case (s)
         2'b00: return {9'd0, lm ? (x | y) : ~(x | y)};
         2'b01: return {9'd0, am ? (x & y) : ~(x & y)};
         2'b10: begin
            if (sm) return {(x < y), 8'd0, 8'(x - y)};
            sum9 = {1'b0, x} + {1'b0, y};
            return {sum9[8], 8'd0, sum9[7:0]};
         end
         default: return {1'b0, 16'(16'(x) * 16'(y))};
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] s, input logic lm, am, sm);
      case (s)
         2'b00: return lm ? "R2" : "R1";
         2'b01: return am ? "R4" : "R3";
         2'b10: return sm ? "R6" : "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic drive(input logic [7:0] x, y, input logic [1:0] s,
                        input logic lm, am, sm, input string tag);
      @(posedge clk);
      #1;
      op_a = x; op_b = y; unit_sel = s;
      lor_mode = lm; land_mode = am; arith_sub = sm;
      exp_q.push_back(model(x, y, s, lm, am, sm));
      tag_q.push_back(tag);
   endtask

   // Monitor: one comparison per cycle, at the falling edge.
   always @(negedge clk) begin
      if (!rst && exp_q.size() > 0) begin
         logic [16:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({cb_flag, res} !== e) begin
            errors++;
            $display("FAIL %s: got flag=%0b res=%h expected flag=%0b res=%h",
                     t, cb_flag, res, e[16], e[15:0]);
         end
      end
   end

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] corner [6];
      corner[0] = 8'h00; corner[1] = 8'hFF; corner[2] = 8'h80;
      corner[3] = 8'h01; corner[4] = 8'h7F; corner[5] = 8'h55;

      // Idle state under reset: all inputs zero selects NOR of zeros (R1).
      repeat (2) @(posedge clk);
      @(negedge clk);
      checks++;
      if ({cb_flag, res} !== 17'h000FF) begin
         errors++;
         $display("FAIL R1: got flag=%0b res=%h expected flag=0 res=00ff", cb_flag, res);
      end
      rst = 1'b0;

      // Every corner pair through every unit and mode.
      for (int i = 0; i < 6; i++)
         for (int j = 0; j < 6; j++)
            for (int s = 0; s < 4; s++)
               for (int m = 0; m < 2; m++)
                  drive(corner[i], corner[j], 2'(s), m[0], m[0], m[0],
                        tag_of(2'(s), m[0], m[0], m[0]));

      // Equal operands: zero difference, no borrow (R6); sum wraps (R5).
      for (int k = 0; k < 16; k++) begin
         logic [7:0] v;
         v = 8'($urandom);
         drive(v, v, 2'b10, 1'b0, 1'b0, 1'b1, "R6");
         drive(v, v, 2'b10, 1'b0, 1'b0, 1'b0, "R5");
      end

      // Flag and upper byte changing in back-to-back vectors (R8, R9).
      drive(8'hFF, 8'hFF, 2'b10, 1'b0, 1'b0, 1'b0, "R5");
      drive(8'hFF, 8'hFF, 2'b11, 1'b0, 1'b0, 1'b0, "R9");
      drive(8'h00, 8'h80, 2'b10, 1'b0, 1'b0, 1'b1, "R6");
      drive(8'h00, 8'h80, 2'b11, 1'b1, 1'b1, 1'b1, "R9");
      drive(8'hFF, 8'hFF, 2'b00, 1'b1, 1'b0, 1'b0, "R8");
      drive(8'hFF, 8'hFF, 2'b01, 1'b0, 1'b1, 1'b1, "R8");
      drive(8'hFF, 8'h01, 2'b10, 1'b0, 1'b0, 1'b0, "R8");

      // Non-selected mode bits toggled with a fixed selection (R10).
      for (int s = 0; s < 4; s++)
         for (int m = 0; m < 8; m++)
            drive(8'hA7, 8'h3C, 2'(s), m[0], m[1], m[2], "R10");

      // Random operands, modes and selections.
      for (int k = 0; k < 600; k++) begin
         logic [7:0] x, y;
         logic [1:0] s;
         logic lm, am, sm;
         x = 8'($urandom); y = 8'($urandom); s = 2'($urandom);
         lm = 1'($urandom); am = 1'($urandom); sm = 1'($urandom);
         drive(x, y, s, lm, am, sm, tag_of(s, lm, am, sm));
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule